// File: doc/BRIEF.md
# Shared-Pin Serial Configuration Loader

This block lets an external controller write a 20-bit control register over two wires: a configuration clock line and a data line. In normal service the data line is an output of the chip, so the block owns the output enable of that pin. Holding the clock line high makes the block let go of the pin. A framing pattern, made of data-line toggles while the clock is high, then opens a write. The controller clocks bits in, most significant first, and closes the write with a second toggle pattern. On that close the received bits are merged into the register in one step and the pin is driven again.

Both lines are oversampled on the fast system clock through a synchronizer, and all edges are found from the sampled levels. A write may be shorter than the register. The bits that arrive fill only the lowest positions, and the last bit received lands in bit 0. If the configuration clock stops toggling for too long during a transfer, the block abandons the transfer, leaves the register as it was and drives the pin again.

Top module: `shared_pin_cfg_loader`

## Requirements
- R1: After reset `cfg_o` equals 20'h00E78, that is bits 3, 4, 5, 6, 9, 10 and 11 are one and all other bits are zero, and `pin_oe_o` is 1.
- R2: While the block is idle, a high level on `cfg_clk_i` drives `pin_oe_o` to 0 at the third `clk` edge after the change. It stays 0 until a write closes (R5) or is abandoned (R9).
- R3: After release, a write opens only after this sequence: the clock goes low, the clock rises with data low, then data rises and then falls while the clock stays high. Clock pulses before the sequence completes deliver no data bits.
- R4: Each data bit is the data level at a clock rise and is accepted at the following clock fall. Bits are shifted in most significant first.
- R5: A write closes when data goes low, then high, then low while the clock is high, and the clock then falls. The register update and `pin_oe_o` returning to 1 both appear at the third `clk` edge after that clock fall. The clock rise that comes just before the closing toggles contributes no bit.
- R6: A write of N bits, N from 0 to 19, sets cfg_o[N-1:0] to those bits with the last one received in bit 0. Every other bit keeps its previous value.
- R7: A write of 20 or more bits sets the whole register to the last 20 bits received.
- R8: `cfg_o` changes only at the moment `pin_oe_o` returns to 1 after a closed write. It never changes while the pin is released or while the block is idle.
- R9: If `cfg_clk_i` shows no edge for TIMEOUT_CYC `clk` cycles while the pin is released, the transfer is abandoned, `pin_oe_o` returns to 1 and `cfg_o` is unchanged.
- R10: If the clock falls after data has risen but before data has fallen in the closing pattern, nothing is committed and the pin stays released until a new opening sequence or the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample both lines |
| rst_n | input | 1 | Active-low reset |
| cfg_clk_i | input | 1 | Configuration clock line, asynchronous |
| cfg_data_i | input | 1 | Level read back from the shared data pin, asynchronous |
| pin_oe_o | output | 1 | Output enable of the shared data pin, 1 means the chip drives it |
| cfg_o | output | 20 | Control register contents |

## Verification
A wrong framing state first appears on `pin_oe_o`. The pin is released too late, is driven back too early, or stays released after a valid close, and each of these shows within three system cycles of the line change that should have moved it. A wrong bit count or a bad shift register stays hidden until the closing fall, because the register changes only at commit. It then shows as wrong or extra low-order bits in `cfg_o`, three cycles after that fall. For that reason the bench compares the pin enable and the register against a behavioural model on every cycle, and writes short, full and over-long words, including a write with no bits at all.

// File: rtl/spl_pkg.sv
package spl_pkg;

    // Framing states of the serial loader; ST_IDLE must stay encoded as zero
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // pin driven, waiting for clock line high
        ST_HOLD  = 3'd1,  // pin released, waiting for clock low
        ST_LOW   = 3'd2,  // clock low, waiting for rise with data low
        ST_HI    = 3'd3,  // clock high, waiting for data rise
        ST_MARK  = 3'd4,  // data high, waiting for data fall
        ST_SHIFT = 3'd5,  // accepting data bits
        ST_STOPA = 3'd6,  // closing marker: data rose
        ST_STOPB = 3'd7   // closing marker: data fell, waiting clock fall
    } spl_state_e;

endpackage

// File: rtl/spl_sync.sv
module spl_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= g_stage[s-1].q;
            end
        end
    end

    assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/spl_idle_timer.sv
module spl_idle_timer #(
    parameter int LIMIT = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic line_edge,
    output logic expire
);

    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign expire = busy && (cnt_q == TW'(LIMIT - 1));

    always_comb begin
        if (!busy || line_edge || expire) cnt_d = '0;
        else                              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spl_frame.sv
module spl_frame
    import spl_pkg::*;
#(
    parameter int  REG_W = 20,
    localparam int CNT_W = $clog2(REG_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             sdat_s,
    input  logic             expire,
    output logic             busy,
    output logic             sclk_edge,
    output logic             commit,
    output logic [CNT_W-1:0] commit_cnt,
    output logic [REG_W-1:0] commit_bits
);

    typedef struct packed {
        spl_state_e       state;
        logic             sclk_p;
        logic             sdat_p;
        logic             pend;
        logic             pend_bit;
        logic [REG_W-1:0] shreg;
        logic [CNT_W-1:0] cnt;
    } frame_t;

    frame_t fr_d, fr_q;

    logic rise, fall, drise, dfall;

    assign rise  =  sclk_s & ~fr_q.sclk_p;
    assign fall  = ~sclk_s &  fr_q.sclk_p;
    assign drise =  sdat_s & ~fr_q.sdat_p;
    assign dfall = ~sdat_s &  fr_q.sdat_p;

    assign busy        = (fr_q.state != ST_IDLE);
    assign sclk_edge   = rise | fall;
    assign commit_cnt  = fr_q.cnt;
    assign commit_bits = fr_q.shreg;

    always_comb begin
        fr_d        = fr_q;
        fr_d.sclk_p = sclk_s;
        fr_d.sdat_p = sdat_s;
        commit      = 1'b0;
        if (expire && busy) begin
            fr_d.state = ST_IDLE;
            fr_d.pend  = 1'b0;
        end else begin
            unique case (fr_q.state)
                ST_IDLE:  if (sclk_s) fr_d.state = ST_HOLD;
                ST_HOLD:  if (fall) fr_d.state = ST_LOW;
                ST_LOW:   if (rise) fr_d.state = sdat_s ? ST_HOLD : ST_HI;
                ST_HI: begin
                    if (fall)       fr_d.state = ST_LOW;
                    else if (drise) fr_d.state = ST_MARK;
                end
                ST_MARK: begin
                    if (fall) begin
                        fr_d.state = ST_LOW;
                    end else if (dfall) begin
                        fr_d.state = ST_SHIFT;
                        fr_d.cnt   = '0;
                        fr_d.pend  = 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (rise) begin
                        // tentative bit: kept only if the clock falls next
                        fr_d.pend     = 1'b1;
                        fr_d.pend_bit = sdat_s;
                    end else if (fall) begin
                        if (fr_q.pend) begin
                            fr_d.shreg = {fr_q.shreg[REG_W-2:0], fr_q.pend_bit};
                            if (fr_q.cnt != CNT_W'(REG_W)) fr_d.cnt = fr_q.cnt + 1'b1;
                        end
                        fr_d.pend = 1'b0;
                    end else if (sclk_s && drise) begin
                        fr_d.state = ST_STOPA;
                        fr_d.pend  = 1'b0;
                    end else if (sclk_s && dfall) begin
                        fr_d.state = ST_HOLD;
                        fr_d.pend  = 1'b0;
                    end
                end
                ST_STOPA: begin
                    if (fall)       fr_d.state = ST_LOW;
                    else if (dfall) fr_d.state = ST_STOPB;
                end
                ST_STOPB: begin
                    if (fall) begin
                        commit     = 1'b1;
                        fr_d.state = ST_IDLE;
                    end else if (drise) begin
                        fr_d.state = ST_HOLD;
                    end
                end
                default: fr_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

endmodule

// File: rtl/shared_pin_cfg_loader.sv
module shared_pin_cfg_loader #(
    parameter int               REG_W       = 20,
    parameter int               SYNC_STAGES = 2,
    parameter int               TIMEOUT_CYC = 25000,
    parameter logic [REG_W-1:0] RESET_VAL   = 'h00E78
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_clk_i,
    input  logic             cfg_data_i,
    output logic             pin_oe_o,
    output logic [REG_W-1:0] cfg_o
);

    localparam int CNT_W = $clog2(REG_W + 1);

    typedef struct packed {
        logic [REG_W-1:0] cfg;
    } reg_t;

    reg_t rg_d, rg_q;

    logic [1:0]       lines_s;
    logic             busy, sclk_edge, commit, expire;
    logic [CNT_W-1:0] commit_cnt;
    logic [REG_W-1:0] commit_bits, new_mask;

    spl_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cfg_clk_i, cfg_data_i}),
        .dout (lines_s)
    );

    spl_frame #(.REG_W(REG_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (lines_s[1]),
        .sdat_s     (lines_s[0]),
        .expire     (expire),
        .busy       (busy),
        .sclk_edge  (sclk_edge),
        .commit     (commit),
        .commit_cnt (commit_cnt),
        .commit_bits(commit_bits)
    );

    spl_idle_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .line_edge(sclk_edge),
        .expire   (expire)
    );

    always_comb begin
        for (int i = 0; i < REG_W; i++) new_mask[i] = (CNT_W'(i) < commit_cnt);
        rg_d = rg_q;
        if (commit) rg_d.cfg = (rg_q.cfg & ~new_mask) | (commit_bits & new_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q.cfg <= RESET_VAL;
        else        rg_q     <= rg_d;
    end

    assign cfg_o    = rg_q.cfg;
    assign pin_oe_o = ~busy;

endmodule

// File: rtl/spl_checker.sv
module spl_checker #(
    parameter int               REG_W       = 20,
    parameter int               TIMEOUT_CYC = 25000,
    parameter logic [REG_W-1:0] RESET_VAL   = 'h00E78
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_clk_i,
    input logic             pin_oe_o,
    input logic [REG_W-1:0] cfg_o
);

    logic [2:0]  hi_run_q;
    int unsigned quiet_q;
    logic        clk_line_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q   <= '0;
            quiet_q    <= 0;
            clk_line_p <= 1'b0;
        end else begin
            clk_line_p <= cfg_clk_i;
            if (pin_oe_o && cfg_clk_i) hi_run_q <= (hi_run_q == 3'd7) ? hi_run_q : hi_run_q + 3'd1;
            else                       hi_run_q <= '0;
            if (pin_oe_o || (clk_line_p != cfg_clk_i)) quiet_q <= 0;
            else if (quiet_q < TIMEOUT_CYC + 8)       quiet_q <= quiet_q + 1;
        end
    end

    // R1: reset state
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> (cfg_o == RESET_VAL && pin_oe_o));

    // R2: pin let go within three cycles of a high clock line
    a_r2_release_latency: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run_q < 3'd4);

    // R8: register moves only when the pin is taken back
    a_r8_change_on_handback: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $rose(pin_oe_o));

    // R8: no change while idle
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe_o && $past(pin_oe_o)) |-> $stable(cfg_o));

    // R9: a silent clock line cannot keep the pin released
    a_r9_inactivity_bound: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q <= TIMEOUT_CYC + 4);

endmodule

bind shared_pin_cfg_loader spl_checker #(
    .REG_W(REG_W), .TIMEOUT_CYC(TIMEOUT_CYC), .RESET_VAL(RESET_VAL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_clk_i(cfg_clk_i),
    .pin_oe_o (pin_oe_o),
    .cfg_o    (cfg_o)
);

// File: tb/shared_pin_cfg_loader_test.sv
module shared_pin_cfg_loader_test;

    localparam int TMO = 300;
    localparam int HP  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_clk = 1'b0;
    logic        line_dat = 1'b0;
    logic        pin_oe_o;
    logic [19:0] cfg_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    bit chk_en   = 0;

    logic        m_oe  = 1'b1;
    logic [19:0] m_cfg = 20'h00E78;
    logic        m_bits[$];

    always #4 clk = ~clk;

    shared_pin_cfg_loader #(.TIMEOUT_CYC(TMO)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_clk_i (line_clk),
        .cfg_data_i(line_dat),
        .pin_oe_o  (pin_oe_o),
        .cfg_o     (cfg_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_en && rst_n && !done) begin
            chk("R2 pin enable", {31'd0, pin_oe_o}, {31'd0, m_oe});
            chk("R8 register", {12'd0, cfg_o}, {12'd0, m_cfg});
        end
    end

    // ev: 0 none, 1 release, 2 commit
    task automatic step(input logic s, input logic d, input int ev);
        @(negedge clk);
        line_clk = s;
        line_dat = d;
        repeat (3) @(posedge clk);
        if (ev == 1) m_oe = 1'b0;
        if (ev == 2) begin
            m_oe = 1'b1;
            for (int j = 0; j < m_bits.size() && j < 20; j++)
                m_cfg[j] = m_bits[m_bits.size() - 1 - j];
            m_bits.delete();
        end
        repeat (HP - 3) @(posedge clk);
    endtask

    task automatic open_seq();
        step(1, 0, 1);
        step(0, 0, 0);
        step(1, 0, 0);
        step(1, 1, 0);
        step(1, 0, 0);
        m_bits.delete();
    endtask

    task automatic send_bit(input logic b);
        step(0, line_dat, 0);
        step(0, b, 0);
        m_bits.push_back(b);
        step(1, b, 0);
    endtask

    task automatic close_seq();
        step(0, line_dat, 0);
        step(0, 0, 0);
        step(1, 0, 0);
        step(1, 1, 0);
        step(1, 0, 0);
        step(0, 0, 2);
    endtask

    task automatic write_word(input int n, input logic [31:0] val);
        open_seq();
        for (int i = n - 1; i >= 0; i--) send_bit(val[i]);
        close_seq();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 reset cfg", {12'd0, cfg_o}, 32'h00E78);
        chk("R1 reset oe", {31'd0, pin_oe_o}, 32'd1);
        chk_en = 1;

        // R2: release latency
        @(negedge clk);
        line_clk = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R2 still driven after 2 edges", {31'd0, pin_oe_o}, 32'd1);
        @(negedge clk);
        chk("R2 released at 3rd edge", {31'd0, pin_oe_o}, 32'd0);
        m_oe = 1'b0;
        // finish the opening sequence from the hold state
        step(0, 0, 0); step(1, 0, 0); step(1, 1, 0); step(1, 0, 0);
        m_bits.delete();
        for (int i = 19; i >= 0; i--) send_bit(20'hA5C3F >> i);
        close_seq();
        chk("R7 R4 full write", {12'd0, cfg_o}, 32'hA5C3F);
        chk("R5 pin driven after close", {31'd0, pin_oe_o}, 32'd1);

        write_word(3, 32'h5);
        chk("R6 three-bit write", {12'd0, cfg_o}, 32'hA5C3D);

        write_word(25, 32'h1ABCDEF);
        chk("R7 over-long write", {12'd0, cfg_o}, 32'hBCDEF);

        // R3: clock pulses before the opening marker carry no bits
        step(1, 0, 1);
        step(0, 1, 0); step(1, 1, 0); step(0, 1, 0); step(1, 1, 0);
        step(0, 0, 0); step(1, 0, 0); step(1, 1, 0); step(1, 0, 0);
        m_bits.delete();
        send_bit(1'b0); send_bit(1'b1);
        close_seq();
        chk("R3 only bits after marker", {12'd0, cfg_o}, 32'hBCDED);

        write_word(0, 32'h0);
        chk("R6 empty write", {12'd0, cfg_o}, 32'hBCDED);

        // R10: clock falls inside the closing marker
        open_seq();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        step(0, 1, 0); step(0, 0, 0); step(1, 0, 0); step(1, 1, 0);
        step(0, 1, 0);
        chk("R10 no commit", {12'd0, cfg_o}, 32'hBCDED);
        chk("R10 pin stays released", {31'd0, pin_oe_o}, 32'd0);

        // R9: silence on the clock line
        chk_en = 0;
        repeat (TMO / 2) @(negedge clk);
        chk("R9 still released before limit", {31'd0, pin_oe_o}, 32'd0);
        repeat (TMO) @(negedge clk);
        chk("R9 pin driven after limit", {31'd0, pin_oe_o}, 32'd1);
        chk("R9 register unchanged", {12'd0, cfg_o}, 32'hBCDED);
        m_oe = 1'b1;
        step(0, 0, 0);
        chk_en = 1;

        write_word(4, 32'hA);
        chk("R6 write after timeout", {12'd0, cfg_o}, 32'hBCDEA);

        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule